// File: doc/BRIEF.md
# Peak-Seeking Switching Period Tracker

This block steers the switching period of a resonant converter toward the period that gives the highest output voltage. It uses a perturb-and-observe search and needs no setpoint and no current sensing. The output voltage has a single maximum where the switching frequency meets the resonant frequency. It rises toward that point from either side. So the tracker keeps stepping the period in one direction while the voltage does not fall, and it turns around when the voltage drops. In steady state it dithers around the peak. When the resonant point drifts, it follows the drift.

Voltage samples arrive on a valid/ready stream, one per update interval. The first sample taken after reset is stored only as a baseline. Each later sample is compared with the one before it, which gives a direction decision and one period step. The new period is held between programmable lower and upper limits. It is presented to a downstream PWM generator together with a one-cycle update strobe. In between strobes the period stays constant, so the generator can latch it at its own cycle boundary. The period, step and limits are counts of the system clock. With a 100 MHz clock, a 16-bit period covers switching frequencies from about 30 kHz to 100 kHz with room to spare.

Back-pressure rules: the tracker never stalls the stream. `smp_ready` is low while reset is asserted, rises on the first clock edge after reset is released, and then stays high. A sample is consumed on every rising edge where `smp_valid` and `smp_ready` are both high. A producer that holds `smp_valid` high for several cycles therefore supplies one sample per cycle.

Top module: `peak_period_tracker`

## Requirements
- R1: `smp_ready` is 0 during reset and 1 from the first edge after reset onward. A sample is consumed exactly on edges where `smp_valid` and `smp_ready` are both 1.
- R2: While reset is asserted, `period_o` equals `cfg_init`, `upd_o` is 0 and `trend_up_o` is 1 (period increasing).
- R3: The first sample consumed after reset is kept only as a baseline. No strobe follows it and `period_o` does not change.
- R4: Each later sample is compared with the previously consumed sample. If it is higher, the direction is kept and the period moves by `cfg_step` in that direction (up adds, down subtracts).
- R5: If a later sample is strictly lower than the previous one, the direction is inverted before the step is applied.
- R6: The stepped period is clamped: above `cfg_hi` it becomes `cfg_hi`, below `cfg_lo` it becomes `cfg_lo`. Arithmetic wrap is replaced by saturation before clamping. This assumes `cfg_lo <= cfg_hi`.
- R7: `upd_o` pulses for exactly one cycle, in the cycle after each consumed non-baseline sample. `period_o` takes its new value in that same cycle and is constant at all other times.
- R8: A sample equal to the previous one counts as not lower, so the direction is kept and the step is taken.
- R9: For an output voltage that is concave in the period, the period settles within two steps of the peak and keeps oscillating there. After the peak moves, it settles again. A peak outside the limits pins the period at the nearer limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Voltage sample present |
| smp_ready | output | 1 | Tracker can take a sample |
| smp_vout | input | VW | Unsigned output-voltage sample |
| cfg_init | input | PW | Period loaded at reset |
| cfg_lo | input | PW | Lowest allowed period |
| cfg_hi | input | PW | Highest allowed period |
| cfg_step | input | PW | Period change per update |
| period_o | output | PW | Period word for the PWM generator |
| upd_o | output | 1 | One-cycle strobe marking a new period |
| trend_up_o | output | 1 | Current search direction, 1 = period increasing |

## Verification
A scoreboard model predicts every period update from the same samples the tracker receives. The stimulus first holds the voltage flat, which separates the tie rule from a reversal. It then feeds a linear concave voltage-versus-period curve with its peak inside the limits, which exercises climbing, reversal at the top and the steady dither band. Moving the peak to the other side of the operating point tests re-acquisition in the opposite direction. Peaks placed beyond each limit show that the clamp pins the period there instead of letting it drift past.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic {
    TREND_DOWN = 1'b0,
    TREND_UP   = 1'b1
  } trend_e;
endpackage

// File: rtl/ppt_sample_hist.sv
// Holds the previously consumed sample and tells whether a new one fell.
module ppt_sample_hist #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [VW-1:0] sample,
  output logic          have_base,
  output logic          fell
);
  logic [VW-1:0] prev_q;
  logic          base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      base_q <= 1'b0;
    end else if (take) begin
      prev_q <= sample;
      base_q <= 1'b1;
    end
  end

  assign have_base = base_q;
  // ties are not a fall, so direction is kept on equal samples
  assign fell      = base_q && (sample < prev_q);

  // R3
  baseline_once_chk: assert property (@(posedge clk) disable iff (rst)
    have_base |=> have_base);
endmodule

// File: rtl/ppt_step_clamp.sv
// One saturating step of the period followed by the limit clamp.
module ppt_step_clamp #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] cur,
  input  logic          go_up,
  input  logic [PW-1:0] step,
  input  logic [PW-1:0] lo,
  input  logic [PW-1:0] hi,
  output logic [PW-1:0] nxt
);
  localparam logic [PW-1:0] ALL_ONES = '1;

  logic [PW:0]   up_sum;
  logic [PW:0]   dn_dif;
  logic [PW-1:0] raw;
  logic [PW-1:0] top_cut;

  always_comb begin
    up_sum = {1'b0, cur} + {1'b0, step};
    dn_dif = {1'b0, cur} - {1'b0, step};
    if (go_up) raw = up_sum[PW] ? ALL_ONES : up_sum[PW-1:0];
    else       raw = dn_dif[PW] ? '0       : dn_dif[PW-1:0];
    top_cut = (raw > hi) ? hi : raw;
    nxt     = (top_cut < lo) ? lo : top_cut;
  end
endmodule

// File: rtl/peak_period_tracker.sv
module peak_period_tracker
  import ppt_pkg::*;
#(
  parameter int VW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [VW-1:0] smp_vout,
  input  logic [PW-1:0] cfg_init,
  input  logic [PW-1:0] cfg_lo,
  input  logic [PW-1:0] cfg_hi,
  input  logic [PW-1:0] cfg_step,
  output logic [PW-1:0] period_o,
  output logic          upd_o,
  output logic          trend_up_o
);
  logic          ready_q;
  logic          fire;
  logic          have_base;
  logic          fell;
  logic          decide;
  trend_e        trend_q;
  trend_e        trend_nxt;
  logic [PW-1:0] period_q;
  logic [PW-1:0] period_nxt;
  logic          upd_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign smp_ready = ready_q;
  assign fire      = smp_valid && ready_q;
  assign decide    = fire && have_base;

  ppt_sample_hist #(.VW(VW)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .take      (fire),
    .sample    (smp_vout),
    .have_base (have_base),
    .fell      (fell)
  );

  assign trend_nxt = fell ? ((trend_q == TREND_UP) ? TREND_DOWN : TREND_UP) : trend_q;

  ppt_step_clamp #(.PW(PW)) u_step (
    .cur   (period_q),
    .go_up (trend_nxt == TREND_UP),
    .step  (cfg_step),
    .lo    (cfg_lo),
    .hi    (cfg_hi),
    .nxt   (period_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= cfg_init;
      trend_q  <= TREND_UP;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (decide) begin
        trend_q  <= trend_nxt;
        period_q <= period_nxt;
        upd_q    <= 1'b1;
      end
    end
  end

  assign period_o   = period_q;
  assign upd_o      = upd_q;
  assign trend_up_o = (trend_q == TREND_UP);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    smp_ready |=> smp_ready);

  // R3
  baseline_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !have_base) |=> (!upd_o && $stable(period_o)));

  // R7
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !decide |=> (!upd_o && $stable(period_o)));

  // R7
  strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
    decide |=> upd_o);

  // R5
  reverse_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && fell) |=> (trend_up_o != $past(trend_up_o)));

  // R6
  within_limits_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && (cfg_lo <= cfg_hi)) |=>
      (period_o >= $past(cfg_lo) && period_o <= $past(cfg_hi)));
endmodule

// File: tb/test_peak_period_tracker.sv
module test_peak_period_tracker;
  localparam int VW = 16;
  localparam int PW = 16;
  localparam int INIT = 2000;
  localparam int LO   = 1000;
  localparam int HI   = 3300;
  localparam int STEP = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [VW-1:0] smp_vout = '0;
  logic [PW-1:0] cfg_init = PW'(INIT);
  logic [PW-1:0] cfg_lo   = PW'(LO);
  logic [PW-1:0] cfg_hi   = PW'(HI);
  logic [PW-1:0] cfg_step = PW'(STEP);
  logic [PW-1:0] period_o;
  logic          upd_o;
  logic          trend_up_o;

  always #10 clk = ~clk;

  peak_period_tracker #(.VW(VW), .PW(PW)) i_peak_period_tracker (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_vout   (smp_vout),
    .cfg_init   (cfg_init),
    .cfg_lo     (cfg_lo),
    .cfg_hi     (cfg_hi),
    .cfg_step   (cfg_step),
    .period_o   (period_o),
    .upd_o      (upd_o),
    .trend_up_o (trend_up_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mon_on = 0;
  int exp_q[$];
  int held = INIT;

  // reference model state
  bit m_base = 0;
  bit m_up = 1;
  int m_prev = 0;
  int m_per = INIT;
  int peak = 2600;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int volt(input int p);
    int d;
    int v;
    d = (p > peak) ? (p - peak) : (peak - p);
    v = 60000 - 8 * d;
    return (v < 0) ? 0 : v;
  endfunction

  // model of R3..R6, R8; pushes the expected period for each strobe
  task automatic model_take(input int v);
    int raw;
    if (!m_base) begin
      m_base = 1;
    end else begin
      if (v < m_prev) m_up = !m_up;
      raw = m_up ? m_per + STEP : m_per - STEP;
      if (raw > 65535) raw = 65535;
      if (raw < 0) raw = 0;
      if (raw > HI) raw = HI;
      if (raw < LO) raw = LO;
      m_per = raw;
      exp_q.push_back(raw);
    end
    m_prev = v;
  endtask

  task automatic send(input int v);
    @(negedge clk);
    model_take(v);
    smp_valid = 1'b1;
    smp_vout  = VW'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) send(volt(m_per));
  endtask

  // monitor: compares strobed periods with the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (upd_o) begin
          if (exp_q.size() == 0) begin
            chk(0, "R7 unexpected strobe", int'(period_o), held);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(period_o) == e, "R4 stepped period", int'(period_o), e);
            chk(period_o >= PW'(LO) && period_o <= PW'(HI), "R6 within limits", int'(period_o), LO);
          end
          held = int'(period_o);
        end else begin
          chk(int'(period_o) == held, "R7 period held between strobes", int'(period_o), held);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset values, R1 ready low in reset
    chk(int'(period_o) == INIT, "R2 reset period", int'(period_o), INIT);
    chk(upd_o == 1'b0, "R2 reset strobe", int'(upd_o), 0);
    chk(trend_up_o == 1'b1, "R2 reset direction", int'(trend_up_o), 1);
    chk(smp_ready == 1'b0, "R1 ready low in reset", int'(smp_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(smp_ready == 1'b1, "R1 ready after reset", int'(smp_ready), 1);
    mon_on = 1;

    // R3 baseline sample only
    send(30000);
    chk(upd_o == 1'b0, "R3 no strobe on baseline", int'(upd_o), 0);
    chk(int'(period_o) == INIT, "R3 period unchanged by baseline", int'(period_o), INIT);

    // R8 equal samples keep the upward direction
    send(30000);
    send(30000);
    send(30000);
    @(negedge clk);
    chk(int'(period_o) == INIT + 3 * STEP, "R8 ties keep direction", int'(period_o), INIT + 3 * STEP);
    chk(trend_up_o == 1'b1, "R8 direction still up", int'(trend_up_o), 1);

    // R5 a falling sample reverses direction
    send(10000);
    @(negedge clk);
    chk(trend_up_o == 1'b0, "R5 reversed on fall", int'(trend_up_o), 0);
    chk(int'(period_o) == INIT + 2 * STEP, "R5 step after reversal", int'(period_o), INIT + 2 * STEP);

    // R9 convergence to a peak inside the limits
    peak = 2600;
    feed(120);
    for (int i = 0; i < 20; i++) begin
      send(volt(m_per));
      @(negedge clk);
      chk(int'(period_o) >= peak - 2 * STEP && int'(period_o) <= peak + 2 * STEP,
          "R9 dither around peak 2600", int'(period_o), peak);
    end

    // R9 peak moves below the operating point
    peak = 1500;
    feed(150);
    for (int i = 0; i < 20; i++) begin
      send(volt(m_per));
      @(negedge clk);
      chk(int'(period_o) >= peak - 2 * STEP && int'(period_o) <= peak + 2 * STEP,
          "R9 re-acquire peak 1500", int'(period_o), peak);
    end

    // R6 peak beyond the upper limit pins at cfg_hi
    peak = 3600;
    feed(200);
    @(negedge clk);
    chk(int'(period_o) == HI, "R6 pinned at upper limit", int'(period_o), HI);

    // R6 peak below the lower limit pins at cfg_lo
    peak = 400;
    feed(250);
    @(negedge clk);
    chk(int'(period_o) == LO, "R6 pinned at lower limit", int'(period_o), LO);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 every expected strobe seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule